// File: doc/BRIEF.md
# Legacy PC Memory Region Decoder

This block sorts every physical address that the processor puts out into one legacy PC memory target. The targets are the system-management RAM window, shadow DRAM in the upper-memory ROM area, the expansion ROM region, the top-of-BIOS alias, the BIOS flash, ordinary main DRAM, and an out-of-range result. Writes that may not land are sorted into a drop result. The result depends on the access kind (read, write or code fetch), on whether the processor is in system-management mode, on the system-management RAM controls, and on separate read and write shadow enables for each 16 KiB area.

The decode is purely combinational from the access inputs to the outputs. A small register port holds the BIOS base address, the control bits and the two shadow enable masks. A register write takes effect on the clock edge that samples it. For ROM targets the block also gives the byte offset into the selected ROM region. For out-of-range reads it gives the fill byte that the bus returns.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset the BIOS base is 0xFFFF0000 and every control bit and shadow enable is clear, so a read at 0xFFFF0000 yields FLASH and a read at 0xA0000 in management mode yields DRAM.
- R2: A read or write in 0xA0000–0xBFFFF yields SMRAM (code 1) when the available bit is set and either the open bit is set or smm_i is high with the restricted bit clear; otherwise it decodes as normal memory.
- R3: A code fetch (kind 2) in 0xA0000–0xBFFFF yields SMRAM when the available bit is set and either the open bit is set or smm_i is high, whatever the restricted bit holds.
- R4: With shadow decode on, 0xC0000–0xFFFFF is split into areas indexed by address bits 17:14. Index values 12 to 15 all select area 12, the one that covers 0xF0000–0xFFFFF.
- R5: With shadow decode on, a read or fetch whose area read-enable bit is set yields SHADOW (code 2). A clear bit yields BIOSTOP (code 4) at 0xE0000 and above, and EXPROM (code 3) below.
- R6: With shadow decode on, a write whose area write-enable bit is set yields SHADOW. A clear bit yields DROP (code 7) with err_o low.
- R7: The BIOSTOP offset is ROM size − 128 KiB + address[16:0]. The EXPROM offset is address[16:0].
- R8: A read or fetch at or above the BIOS base and below 4 GiB yields FLASH (code 5) with offset address[ROM_AW-1:0]. Main DRAM below DRAM_TOP that is not BIOS is decoded first.
- R9: A read or fetch at or above 4 GiB, or at or above DRAM_TOP outside the BIOS range, yields OOR (code 6) with err_o high and fill_o = 0xFF. Every other target gives fill_o = 0x00.
- R10: A write at or above DRAM_TOP, or in the BIOS range, yields DROP with err_o high.
- R11: Accesses below DRAM_TOP that lie outside 0xC0000–0xFFFFF, outside the BIOS range and are not taken by SMRAM yield DRAM (code 0) with err_o low.
- R12: Register writes with cfg_we_i high apply at that clock edge. The selects are: 0 = BIOS base, 1 = controls (bit0 available, bit1 open, bit2 restricted, bit3 shadow decode on), 2 = read-enable mask, 3 = write-enable mask (bit n is area n).
- R13: With shadow decode off, reads of 0xC0000–0xFFFFF go to ROM whatever the enable masks hold (BIOSTOP or EXPROM, as in R5). Writes there yield DROP with err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the register port |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| acc_addr_i | input | ADDR_W | Physical address of the access |
| acc_kind_i | input | 2 | 0 read, 1 write, 2 code fetch (3 acts as read) |
| smm_i | input | 1 | Processor is in system-management mode |
| tgt_o | output | 3 | Target code |
| rom_off_o | output | ROM_AW | Offset into the selected ROM region |
| err_o | output | 1 | Access is out of range or rejected |
| fill_o | output | 8 | Data byte returned for out-of-range reads |

## Verification
The SMRAM window is probed with every mix of management mode, open bit and restricted bit, for both data reads and code fetches. This separates the fetch rule from the data rule. Shadow areas are swept with alternating enable masks and with decode both on and off, which shows clamping of the upper indices and keeps the read and write masks apart. Addresses just below and above the BIOS base, DRAM_TOP and 4 GiB show the order of BIOS, main DRAM and out-of-range decoding. The same addresses are written to show the drop-with-error case apart from the silent discard.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

   localparam logic [2:0] TGT_DRAM    = 3'd0;
   localparam logic [2:0] TGT_SMRAM   = 3'd1;
   localparam logic [2:0] TGT_SHADOW  = 3'd2;
   localparam logic [2:0] TGT_EXPROM  = 3'd3;
   localparam logic [2:0] TGT_BIOSTOP = 3'd4;
   localparam logic [2:0] TGT_FLASH   = 3'd5;
   localparam logic [2:0] TGT_OOR     = 3'd6;
   localparam logic [2:0] TGT_DROP    = 3'd7;

   localparam logic [1:0] KIND_READ  = 2'd0;
   localparam logic [1:0] KIND_WRITE = 2'd1;
   localparam logic [1:0] KIND_FETCH = 2'd2;

   localparam logic [1:0] SEL_BASE  = 2'd0;
   localparam logic [1:0] SEL_CTRL  = 2'd1;
   localparam logic [1:0] SEL_RDMSK = 2'd2;
   localparam logic [1:0] SEL_WRMSK = 2'd3;

   localparam logic [31:0] BASE_RESET = 32'hFFFF_0000;

   typedef struct packed {
      logic decode_on;
      logic restricted;
      logic open;
      logic avail;
   } mrd_ctrl_t;

endpackage

// File: rtl/mrd_regs.sv
module mrd_regs
   import mrd_pkg::*;
#(
   parameter int NUM_AREAS = 13
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 we_i,
   input  logic [1:0]           sel_i,
   input  logic [31:0]          wdata_i,
   output logic [31:0]          base_o,
   output mrd_ctrl_t            ctrl_o,
   output logic [NUM_AREAS-1:0] rd_en_o,
   output logic [NUM_AREAS-1:0] wr_en_o
);

   localparam int CTRL_W = $bits(mrd_ctrl_t);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         base_o  <= BASE_RESET;
         ctrl_o  <= '0;
         rd_en_o <= '0;
         wr_en_o <= '0;
      end else if (we_i) begin
         case (sel_i)
            SEL_BASE:  base_o  <= wdata_i;
            SEL_CTRL:  ctrl_o  <= mrd_ctrl_t'(wdata_i[CTRL_W-1:0]);
            SEL_RDMSK: rd_en_o <= wdata_i[NUM_AREAS-1:0];
            default:   wr_en_o <= wdata_i[NUM_AREAS-1:0];
         endcase
      end
   end

   // R12
   base_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == SEL_BASE) |=> (base_o == $past(wdata_i)));

   // R12
   mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i) |=> ($stable(rd_en_o) && $stable(wr_en_o)));

endmodule

// File: rtl/mrd_smram_gate.sv
module mrd_smram_gate
   import mrd_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      in_window_i,
   input  logic      fetch_i,
   input  logic      smm_i,
   input  mrd_ctrl_t ctrl_i,
   output logic      use_o
);

   logic data_open;
   logic code_open;

   assign data_open = ctrl_i.open | (smm_i & ~ctrl_i.restricted);
   assign code_open = ctrl_i.open | smm_i;
   assign use_o     = in_window_i & ctrl_i.avail & (fetch_i ? code_open : data_open);

   // R3
   fetch_ignores_restrict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_window_i && fetch_i && ctrl_i.avail && smm_i) |-> use_o);

   // R2
   data_restrict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fetch_i && ctrl_i.restricted && !ctrl_i.open) |-> !use_o);

endmodule

// File: rtl/mrd_area_map.sv
module mrd_area_map #(
   parameter int NUM_AREAS = 13,
   parameter int IDX_W     = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [IDX_W-1:0]     idx_i,
   input  logic [NUM_AREAS-1:0] rd_en_i,
   input  logic [NUM_AREAS-1:0] wr_en_i,
   output logic                 rd_dram_o,
   output logic                 wr_dram_o
);

   localparam int LAST = NUM_AREAS - 1;

   logic [NUM_AREAS-1:0] hit;

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
      if (g == LAST) begin : g_top
         assign hit[g] = (int'(idx_i) >= LAST);
      end else begin : g_mid
         assign hit[g] = (int'(idx_i) == g);
      end
   end

   assign rd_dram_o = |(hit & rd_en_i);
   assign wr_dram_o = |(hit & wr_en_i);

   // R4
   area_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit) == 1);

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
   import mrd_pkg::*;
#(
   parameter int          ADDR_W     = 36,
   parameter int          ROM_AW     = 18,
   parameter logic [63:0] DRAM_TOP   = 64'h0200_0000,
   parameter int          NUM_AREAS  = 13,
   parameter int          AREA_SHIFT = 14
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [1:0]        cfg_sel_i,
   input  logic [31:0]       cfg_wdata_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic [1:0]        acc_kind_i,
   input  logic              smm_i,
   output logic [2:0]        tgt_o,
   output logic [ROM_AW-1:0] rom_off_o,
   output logic              err_o,
   output logic [7:0]        fill_o
);

   localparam int                IDX_W      = 4;
   localparam logic [ADDR_W-1:0] TOP        = ADDR_W'(DRAM_TOP);
   localparam logic [ADDR_W-1:0] WIN_LO     = ADDR_W'(32'h000A_0000);
   localparam logic [ADDR_W-1:0] LOW_LO     = ADDR_W'(32'h000C_0000);
   localparam logic [ADDR_W-1:0] UPPER_LO   = ADDR_W'(32'h000E_0000);
   localparam logic [ADDR_W-1:0] MEG        = ADDR_W'(32'h0010_0000);
   localparam logic [ROM_AW-1:0] ALIAS_BASE = ROM_AW'((64'd1 << ROM_AW) - 64'h2_0000);

   if (ADDR_W < 32) begin : g_bad_addr
      $error("ADDR_W must be at least 32");
   end
   if (ROM_AW < 17 || ROM_AW > ADDR_W) begin : g_bad_rom
      $error("ROM_AW must lie between 17 and ADDR_W");
   end
   if (NUM_AREAS < 1 || NUM_AREAS > 16) begin : g_bad_areas
      $error("NUM_AREAS must lie between 1 and 16");
   end
   if (DRAM_TOP < 64'h10_0000 || DRAM_TOP > 64'h1_0000_0000) begin : g_bad_top
      $error("DRAM_TOP must lie between 1 MiB and 4 GiB");
   end

   logic [31:0]          bios_base;
   mrd_ctrl_t            ctrl;
   logic [NUM_AREAS-1:0] rd_en;
   logic [NUM_AREAS-1:0] wr_en;

   mrd_regs #(.NUM_AREAS(NUM_AREAS)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .sel_i   (cfg_sel_i),
      .wdata_i (cfg_wdata_i),
      .base_o  (bios_base),
      .ctrl_o  (ctrl),
      .rd_en_o (rd_en),
      .wr_en_o (wr_en)
   );

   logic kind_wr, kind_fe;
   logic in_win, in_low, in_upper, below_top, above_4g, in_bios;
   logic [ADDR_W-1:0] base_ext;

   assign kind_wr   = (acc_kind_i == KIND_WRITE);
   assign kind_fe   = (acc_kind_i == KIND_FETCH);
   assign base_ext  = ADDR_W'(bios_base);
   assign in_win    = (acc_addr_i >= WIN_LO) && (acc_addr_i < LOW_LO);
   assign in_low    = (acc_addr_i >= LOW_LO) && (acc_addr_i < MEG);
   assign in_upper  = (acc_addr_i >= UPPER_LO);
   assign below_top = (acc_addr_i < TOP);

   if (ADDR_W > 32) begin : g_wide
      assign above_4g = |acc_addr_i[ADDR_W-1:32];
   end else begin : g_narrow
      assign above_4g = 1'b0;
   end

   assign in_bios = !above_4g && (acc_addr_i >= base_ext);

   logic use_smram;

   mrd_smram_gate u_smram (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .in_window_i (in_win),
      .fetch_i     (kind_fe),
      .smm_i       (smm_i),
      .ctrl_i      (ctrl),
      .use_o       (use_smram)
   );

   logic rd_dram, wr_dram;

   mrd_area_map #(.NUM_AREAS(NUM_AREAS), .IDX_W(IDX_W)) u_area (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idx_i     (acc_addr_i[AREA_SHIFT+IDX_W-1:AREA_SHIFT]),
      .rd_en_i   (rd_en),
      .wr_en_i   (wr_en),
      .rd_dram_o (rd_dram),
      .wr_dram_o (wr_dram)
   );

   logic [ROM_AW-1:0] off_alias, off_exp, off_flash;

   assign off_alias = ALIAS_BASE + ROM_AW'(acc_addr_i[16:0]);
   assign off_exp   = ROM_AW'(acc_addr_i[16:0]);
   assign off_flash = acc_addr_i[ROM_AW-1:0];

   always_comb begin
      tgt_o     = TGT_DRAM;
      rom_off_o = '0;
      err_o     = 1'b0;
      if (use_smram) begin
         tgt_o = TGT_SMRAM;
      end else if (ctrl.decode_on && in_low) begin
         if (kind_wr) begin
            tgt_o = wr_dram ? TGT_SHADOW : TGT_DROP;
         end else if (rd_dram) begin
            tgt_o = TGT_SHADOW;
         end else if (in_upper) begin
            tgt_o     = TGT_BIOSTOP;
            rom_off_o = off_alias;
         end else begin
            tgt_o     = TGT_EXPROM;
            rom_off_o = off_exp;
         end
      end else if (kind_wr) begin
         if (!below_top || in_bios) begin
            tgt_o = TGT_DROP;
            err_o = 1'b1;
         end else if (in_low) begin
            tgt_o = TGT_DROP;
         end
      end else if (below_top && !in_bios) begin
         if (in_low && in_upper) begin
            tgt_o     = TGT_BIOSTOP;
            rom_off_o = off_alias;
         end else if (in_low) begin
            tgt_o     = TGT_EXPROM;
            rom_off_o = off_exp;
         end
      end else if (in_bios) begin
         tgt_o     = TGT_FLASH;
         rom_off_o = off_flash;
      end else begin
         tgt_o = TGT_OOR;
         err_o = 1'b1;
      end
   end

   assign fill_o = (tgt_o == TGT_OOR) ? 8'hFF : 8'h00;

   // R2
   smram_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_o == TGT_SMRAM) |-> (acc_addr_i >= WIN_LO && acc_addr_i < LOW_LO));

   // R8
   flash_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_o == TGT_FLASH) |-> (acc_addr_i >= ADDR_W'(bios_base) && !kind_wr));

   // R9
   oor_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_o == TGT_OOR) |-> (err_o && fill_o == 8'hFF && !kind_wr));

   // R7
   alias_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_o == TGT_BIOSTOP) |-> (rom_off_o[16:0] == acc_addr_i[16:0]));

   // R6
   shadow_drop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_wr && in_low && ctrl.decode_on) |-> !err_o);

endmodule

// File: tb/tb_legacy_mem_decoder.sv
module tb_legacy_mem_decoder;

   localparam int    ADDR_W = 36;
   localparam int    ROM_AW = 18;
   localparam longint TOPV  = 64'h0200_0000;
   localparam longint ROMSZ = 64'd1 << ROM_AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = '0;
   logic [31:0]       cfg_wdata = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic [1:0]        kind = '0;
   logic              smm = 1'b0;
   logic [2:0]        tgt;
   logic [ROM_AW-1:0] off;
   logic              err;
   logic [7:0]        fill;

   always #5 clk = ~clk;

   legacy_mem_decoder dut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
      .cfg_wdata_i(cfg_wdata), .acc_addr_i(addr), .acc_kind_i(kind), .smm_i(smm),
      .tgt_o(tgt), .rom_off_o(off), .err_o(err), .fill_o(fill)
   );

   int tests = 0;
   int fails = 0;
   bit done = 0;

   longint m_base = 64'hFFFF_0000;
   bit m_avail = 0, m_open = 0, m_restr = 0, m_dec = 0;
   bit [12:0] m_rd = '0, m_wr = '0;

   function automatic void model(input int k, input longint a, input bit s,
                                 output int t, output longint o, output bit e);
      bit isbios, low, big;
      int ar;
      t = 0; o = 0; e = 0;
      big    = a >= 64'h1_0000_0000;
      isbios = !big && a >= m_base;
      low    = a >= 64'hC0000 && a < 64'h100000;
      if (a >= 64'hA0000 && a < 64'hC0000 && m_avail &&
          (m_open || (s && (k == 2 || !m_restr)))) begin
         t = 1;
         return;
      end
      if (m_dec && low) begin
         ar = int'((a / 16384) % 16);
         if (ar > 12) ar = 12;
         if (k == 1) begin
            t = m_wr[ar] ? 2 : 7;
         end else if (m_rd[ar]) begin
            t = 2;
         end else if (a >= 64'hE0000) begin
            t = 4; o = ROMSZ - 131072 + (a % 131072);
         end else begin
            t = 3; o = a % 131072;
         end
         return;
      end
      if (k == 1) begin
         if (a >= TOPV || isbios) begin t = 7; e = 1; end
         else if (low) t = 7;
         return;
      end
      if (a < TOPV && !isbios) begin
         if (low && a >= 64'hE0000) begin t = 4; o = ROMSZ - 131072 + (a % 131072); end
         else if (low) begin t = 3; o = a % 131072; end
      end else if (isbios) begin
         t = 5; o = a % ROMSZ;
      end else begin
         t = 6; e = 1;
      end
   endfunction

   task automatic probe(input int k, input longint a, input bit s, input string req);
      int et; longint eo; bit ee;
      @(posedge clk);
      #1;
      kind = 2'(k); addr = ADDR_W'(a); smm = s;
      @(negedge clk);
      model(k, a, s, et, eo, ee);
      tests++;
      if (int'(tgt) != et || longint'(off) != eo || err != ee ||
          fill != (et == 6 ? 8'hFF : 8'h00)) begin
         fails++;
         $display("FAIL %s kind=%0d addr=%h smm=%0d: got tgt=%0d off=%h err=%0d fill=%h, expected tgt=%0d off=%h err=%0d",
                  req, k, a, s, tgt, off, err, fill, et, eo, ee);
      end
   endtask

   task automatic cfg(input int sel, input logic [31:0] d);
      @(posedge clk);
      #1;
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      case (sel)
         0: m_base = longint'(d);
         1: begin m_avail = d[0]; m_open = d[1]; m_restr = d[2]; m_dec = d[3]; end
         2: m_rd = d[12:0];
         default: m_wr = d[12:0];
      endcase
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      probe(0, 64'hFFFF_0000, 0, "R1");
      probe(0, 64'hA0000, 1, "R1");
      // R11 main DRAM
      probe(0, 64'h1000, 0, "R11");
      probe(1, 64'h50000, 0, "R11");
      probe(2, 64'h100000, 0, "R11");
      probe(1, 64'hB0000, 1, "R11");
      // R8 flash
      probe(0, 64'hFFFF_FFF0, 0, "R8");
      probe(2, 64'hFFFF_8000, 0, "R8");
      // R9 out of range
      probe(0, 64'hFFFE_FFFF, 0, "R9");
      probe(0, 64'h0300_0000, 0, "R9");
      probe(0, 64'h1_0000_0000, 0, "R9");
      probe(2, 64'hF_FFFF_FFF0, 0, "R9");
      // R10 rejected writes
      probe(1, 64'hFFFF_0000, 0, "R10");
      probe(1, 64'h0300_0000, 0, "R10");
      probe(1, 64'h1_0000_0010, 0, "R10");
      // R12 register port: move base down
      cfg(0, 32'hFFFC_0000);
      probe(0, 64'hFFFC_0000, 0, "R12");
      probe(0, 64'hFFFB_FFFF, 0, "R12");
      probe(1, 64'hFFFC_0004, 0, "R12");
      // R13 shadow decode off, masks set but ignored
      cfg(2, 32'h1FFF);
      cfg(3, 32'h1FFF);
      probe(0, 64'hC8000, 0, "R13");
      probe(0, 64'hF1234, 0, "R13");
      probe(2, 64'hE0000, 0, "R13");
      probe(1, 64'hD0000, 0, "R13");
      // R7 offsets
      probe(0, 64'hDFFFF, 0, "R7");
      probe(0, 64'hFFFFF, 0, "R7");
      // R2 data rule
      cfg(1, 32'h1);
      probe(0, 64'hA0000, 1, "R2");
      probe(0, 64'hA0000, 0, "R2");
      probe(1, 64'hBFFFF, 1, "R2");
      cfg(1, 32'h5);
      probe(0, 64'hA8000, 1, "R2");
      probe(1, 64'hA8000, 1, "R2");
      // R3 fetch rule ignores restricted
      probe(2, 64'hA8000, 1, "R3");
      probe(2, 64'hA8000, 0, "R3");
      cfg(1, 32'h7);
      probe(0, 64'hA8000, 0, "R2");
      probe(2, 64'hBFFF0, 0, "R3");
      cfg(1, 32'h6);
      probe(2, 64'hA0000, 1, "R3");
      probe(0, 64'hA0000, 1, "R2");
      // R5 shadow reads with decode on
      cfg(1, 32'h8);
      cfg(2, 32'h1004);
      cfg(3, 32'h0008);
      probe(0, 64'hC8000, 0, "R5");
      probe(0, 64'hCC000, 0, "R5");
      probe(0, 64'hE4000, 0, "R5");
      probe(2, 64'hF0010, 0, "R5");
      // R4 clamped upper indices
      probe(0, 64'hF8000, 0, "R4");
      probe(0, 64'hFC000, 0, "R4");
      // R6 shadow writes
      probe(1, 64'hCC000, 0, "R6");
      probe(1, 64'hC8000, 0, "R6");
      probe(1, 64'hFFFFF, 0, "R6");
      cfg(3, 32'h1000);
      probe(1, 64'hFFFFF, 0, "R6");
      probe(1, 64'hF4000, 0, "R4");
      // R4 sweep over every index with alternating masks
      cfg(2, 32'h0A5A);
      cfg(3, 32'h15A5);
      for (int i = 0; i < 16; i++) begin
         probe(0, 64'hC0000 + longint'(i) * 16384 + 64'h10, 0, "R4");
         probe(1, 64'hC0000 + longint'(i) * 16384 + 64'h20, 0, "R4");
      end
      cfg(2, 32'h1000);
      probe(0, 64'hEC000, 0, "R5");
      probe(0, 64'hF0000, 0, "R5");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule